// File: doc/BRIEF.md
# Reprogrammable Two-Digit Combination Lock

This block is a clocked Moore machine guarding a door or similar resource. A user sets a 2-bit code and pulses `enter` to confirm it, then does the same for the second digit. Both stored digits sit in registers inside the block. When both entered digits match, the lock opens. A wrong first digit is not reported at once. The machine goes on and accepts a second digit, and only then shows the error, so an observer cannot tell which digit was wrong.

While the lock is open, further `enter` pulses step through two programming states. Each of these stores the current code as a new digit. Two reset inputs act independently. `rst` returns the sequence to its idle state and leaves the stored combination alone. `combo_rst` reloads the default combination.

Top module: `combo_lock`

## Requirements
- R1: Asserting `combo_rst` loads the default combination, first digit 2'b11 and second digit 2'b01. After it, entering 11 then 01 opens the lock.
- R2: `rst` sends the machine to idle with all four indications low, and the stored combination is unchanged.
- R3: In idle, an enter whose code equals the first stored digit moves to a first-ok state. Any other code moves to a first-bad state. Neither state drives any indication.
- R4: In the first-ok state, an enter whose code equals the second stored digit opens the lock (`unlocked`=1). Any other code moves to the denied state (`denied`=1).
- R5: In the first-bad state, any enter moves to the denied state, whatever the code.
- R6: In the open state, enter moves to the first-programming state (`set_first`=1). There, enter stores the code as the new first digit and moves to the second-programming state (`set_second`=1).
- R7: In the second-programming state, enter stores the code as the new second digit and returns to the open state.
- R8: In the denied state, enter returns to idle.
- R9: At most one of `unlocked`, `denied`, `set_first` and `set_second` is high at any time. Without an enter pulse the state does not change.
- R10: When `rst` and `combo_rst` are both asserted, both take effect. When `combo_rst` meets a digit write in the same cycle, `combo_rst` wins. A write requested while `rst` is high is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous sequence reset, active high |
| combo_rst | input | 1 | Synchronous reload of the default combination, active high |
| enter | input | 1 | Single-cycle strobe that confirms the current code |
| code | input | 2 | Digit presented by the user |
| unlocked | output | 1 | Lock open indication |
| denied | output | 1 | Wrong combination indication |
| set_first | output | 1 | Programming the first digit |
| set_second | output | 1 | Programming the second digit |

## Verification
The bench builds the block with its default parameters: 2-bit digits and the default combination 11, 01. With a code space of only four values, every match and mismatch case of both digits can be hit directly. The bench reprograms the lock to 00, 10 and then checks that this combination survives a sequence reset. It also drives simultaneous reset, write and reload cycles, so the priority rules are observed through which combination opens the lock afterwards.

// File: rtl/combo_lock_pkg.sv
package combo_lock_pkg;
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_FIRST_OK   = 3'd1,
        ST_FIRST_BAD  = 3'd2,
        ST_UNLOCKED   = 3'd3,
        ST_SET_FIRST  = 3'd4,
        ST_SET_SECOND = 3'd5,
        ST_DENIED     = 3'd6
    } lock_state_e;

    typedef struct packed {
        lock_state_e state;
    } fsm_regs_t;
endpackage

// File: rtl/lock_digit_store.sv
module lock_digit_store #(
    parameter int DIGIT_W = 2,
    parameter logic [DIGIT_W-1:0] DEF_FIRST  = 2'b11,
    parameter logic [DIGIT_W-1:0] DEF_SECOND = 2'b01
) (
    input  logic               clk,
    input  logic               combo_rst,
    input  logic               wr_first,
    input  logic               wr_second,
    input  logic [DIGIT_W-1:0] code,
    output logic [DIGIT_W-1:0] first_q,
    output logic [DIGIT_W-1:0] second_q
);
    typedef struct packed {
        logic [DIGIT_W-1:0] first;
        logic [DIGIT_W-1:0] second;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (combo_rst) begin
            s_d.first  = DEF_FIRST;
            s_d.second = DEF_SECOND;
        end else begin
            if (wr_first)  s_d.first  = code;
            if (wr_second) s_d.second = code;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign first_q  = s_q.first;
    assign second_q = s_q.second;
endmodule

// File: rtl/lock_seq_fsm.sv
module lock_seq_fsm
    import combo_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enter,
    input  logic        match_first,
    input  logic        match_second,
    output lock_state_e state_q,
    output logic        wr_first,
    output logic        wr_second
);
    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (enter) begin
            case (r_q.state)
                ST_IDLE:       r_d.state = match_first  ? ST_FIRST_OK : ST_FIRST_BAD;
                ST_FIRST_OK:   r_d.state = match_second ? ST_UNLOCKED : ST_DENIED;
                ST_FIRST_BAD:  r_d.state = ST_DENIED;
                ST_UNLOCKED:   r_d.state = ST_SET_FIRST;
                ST_SET_FIRST:  r_d.state = ST_SET_SECOND;
                ST_SET_SECOND: r_d.state = ST_UNLOCKED;
                ST_DENIED:     r_d.state = ST_IDLE;
                default:       r_d.state = ST_IDLE;
            endcase
        end else if (r_q.state == ST_IDLE || r_q.state == ST_FIRST_OK ||
                     r_q.state == ST_FIRST_BAD || r_q.state == ST_UNLOCKED ||
                     r_q.state == ST_SET_FIRST || r_q.state == ST_SET_SECOND ||
                     r_q.state == ST_DENIED) begin
            r_d.state = r_q.state;
        end else begin
            r_d.state = ST_IDLE;
        end
        if (rst) r_d.state = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign state_q   = r_q.state;
    assign wr_first  = enter && !rst && (r_q.state == ST_SET_FIRST);
    assign wr_second = enter && !rst && (r_q.state == ST_SET_SECOND);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!enter && $past(!rst)) |=> $stable(state_q));
    p_bad_to_denied_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FIRST_BAD && enter) |=> (state_q == ST_DENIED));
    p_denied_exit_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DENIED && enter) |=> (state_q == ST_IDLE));
    p_unlock_prog_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_UNLOCKED && enter) |=> (state_q == ST_SET_FIRST));
    p_reset_idle_r2: assert property (@(posedge clk)
        rst |=> (state_q == ST_IDLE));
endmodule

// File: rtl/lock_out_decode.sv
module lock_out_decode
    import combo_lock_pkg::*;
(
    input  lock_state_e state,
    output logic        unlocked,
    output logic        denied,
    output logic        set_first,
    output logic        set_second
);
    always_comb begin
        unlocked   = 1'b0;
        denied     = 1'b0;
        set_first  = 1'b0;
        set_second = 1'b0;
        case (state)
            ST_UNLOCKED:   unlocked   = 1'b1;
            ST_DENIED:     denied     = 1'b1;
            ST_SET_FIRST:  set_first  = 1'b1;
            ST_SET_SECOND: set_second = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/combo_lock.sv
module combo_lock
    import combo_lock_pkg::*;
#(
    parameter int DIGIT_W = 2,
    parameter logic [DIGIT_W-1:0] DEF_FIRST  = 2'b11,
    parameter logic [DIGIT_W-1:0] DEF_SECOND = 2'b01
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               combo_rst,
    input  logic               enter,
    input  logic [DIGIT_W-1:0] code,
    output logic               unlocked,
    output logic               denied,
    output logic               set_first,
    output logic               set_second
);
    logic [DIGIT_W-1:0] first_q, second_q;
    logic               wr_first, wr_second;
    lock_state_e        state_q;

    lock_digit_store #(
        .DIGIT_W(DIGIT_W), .DEF_FIRST(DEF_FIRST), .DEF_SECOND(DEF_SECOND)
    ) u_store (
        .clk(clk), .combo_rst(combo_rst), .wr_first(wr_first),
        .wr_second(wr_second), .code(code),
        .first_q(first_q), .second_q(second_q)
    );

    lock_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .enter(enter),
        .match_first(code == first_q), .match_second(code == second_q),
        .state_q(state_q), .wr_first(wr_first), .wr_second(wr_second)
    );

    lock_out_decode u_dec (
        .state(state_q), .unlocked(unlocked), .denied(denied),
        .set_first(set_first), .set_second(set_second)
    );

    p_one_ind_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({unlocked, denied, set_first, set_second}));
    p_defaults_r1: assert property (@(posedge clk) disable iff (rst)
        combo_rst |=> (first_q == DEF_FIRST && second_q == DEF_SECOND));
    p_store_first_r6: assert property (@(posedge clk) disable iff (rst)
        (set_first && enter && !combo_rst) |=> (first_q == $past(code)));
    p_store_second_r7: assert property (@(posedge clk) disable iff (rst)
        (set_second && enter && !combo_rst) |=> (second_q == $past(code) && unlocked));
endmodule

// File: tb/combo_lock_bench.sv
`timescale 1ns/1ps
module combo_lock_bench;
    logic clk = 1'b0;
    logic rst, combo_rst, enter;
    logic [1:0] code;
    logic unlocked, denied, set_first, set_second;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int m_state = 0;
    int m_d1 = 3;
    int m_d2 = 1;

    always #2.5 clk = ~clk;

    combo_lock u_combo_lock (
        .clk(clk), .rst(rst), .combo_rst(combo_rst), .enter(enter), .code(code),
        .unlocked(unlocked), .denied(denied), .set_first(set_first), .set_second(set_second)
    );

    task automatic model_update(input bit r, input bit cr, input bit en, input int c);
        int ns = m_state;
        if (en) begin
            if (m_state == 0)      ns = (c == m_d1) ? 1 : 2;
            else if (m_state == 1) ns = (c == m_d2) ? 3 : 6;
            else if (m_state == 2) ns = 6;
            else if (m_state == 3) ns = 4;
            else if (m_state == 4) begin ns = 5; if (!r) m_d1 = c; end
            else if (m_state == 5) begin ns = 3; if (!r) m_d2 = c; end
            else                   ns = 0;
        end
        if (cr) begin m_d1 = 3; m_d2 = 1; end
        m_state = r ? 0 : ns;
    endtask

    task automatic step(input bit r, input bit cr, input bit en, input int c, input string tag);
        logic [3:0] exp_v, act_v;
        @(negedge clk);
        rst = r; combo_rst = cr; enter = en; code = c[1:0];
        @(posedge clk);
        #1;
        model_update(r, cr, en, c);
        exp_v = {m_state == 3, m_state == 6, m_state == 4, m_state == 5};
        act_v = {unlocked, denied, set_first, set_second};
        checks++;
        if (act_v !== exp_v) begin
            failures++;
            $display("FAIL %s: outputs {open,denied,p1,p2} actual=%b expected=%b", tag, act_v, exp_v);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; combo_rst = 1'b1; enter = 1'b0; code = 2'b00;
        step(1, 1, 0, 0, "R10 both resets");
        step(0, 0, 0, 0, "R2 reset state");
        step(0, 0, 1, 3, "R3 first ok");
        step(0, 0, 0, 2, "R9 hold no enter");
        step(0, 0, 1, 1, "R1 default opens");
        step(0, 0, 0, 0, "R9 open holds");
        step(0, 0, 1, 2, "R6 to prog1");
        step(0, 0, 1, 0, "R6 store first");
        step(0, 0, 1, 2, "R7 store second");
        step(1, 0, 0, 0, "R2 reset");
        step(0, 0, 1, 3, "R3 wrong first");
        step(0, 0, 0, 3, "R3 bad silent");
        step(0, 0, 1, 2, "R5 bad then denied");
        step(0, 0, 0, 0, "R9 denied holds");
        step(0, 0, 1, 0, "R8 denied to idle");
        step(0, 0, 1, 0, "R3 new first ok");
        step(0, 0, 1, 3, "R4 wrong second");
        step(0, 0, 1, 0, "R8 back idle");
        step(0, 0, 1, 0, "R2 combo kept first");
        step(0, 0, 1, 2, "R2 combo kept opens");
        step(0, 0, 1, 0, "R6 prog1");
        step(0, 1, 1, 2, "R10 reload beats write1");
        step(0, 1, 1, 0, "R10 reload beats write2");
        step(1, 0, 0, 0, "R2 reset");
        step(0, 0, 1, 0, "R1 old first rejected");
        step(0, 0, 1, 1, "R5 denied");
        step(0, 0, 1, 1, "R8 idle");
        step(0, 0, 1, 3, "R1 default first");
        step(0, 0, 1, 1, "R1 default opens again");
        step(0, 0, 1, 0, "R6 prog1 again");
        step(1, 0, 1, 2, "R10 write dropped on reset");
        step(0, 0, 1, 3, "R10 first still 11");
        step(0, 0, 1, 1, "R10 still opens");
        step(0, 0, 0, 0, "R9 final hold");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule